// File: doc/BRIEF.md
# Accumulator Multi-Cycle Processor Core

This block is a small stored-program processor built around one accumulator. Both data and instructions are 16-bit words. An instruction keeps its operation code in the top four bits and a 12-bit word address in the low twelve. The core owns a word-addressed 4K-word synchronous memory. Every instruction runs as a fixed series of register transfers through a memory address register and a memory buffer register. A control state machine steps through fetch, decode, operand read and execute. Indirect forms add one more address step.

A host fills the memory while the `run` input is low, using a write port. It then raises `run`, and the core starts fetching at address 0. When the core executes a halt instruction, it freezes and raises `halted`. The host lowers `run` again and reads the results back through the same port. An 8-bit input register captures `in_data` when `in_stb` pulses, and the input instruction reads it. The output instruction drives the 8-bit output register, which appears on `out_data`.

Top module: `acc_core`

## Requirements
- R1: Reset is synchronous and active-low. After reset, `halted` is 0, `out_data` is 0, PC is 0 and the accumulator is 0.
- R2: An instruction is fetched from M[PC] and PC then advances by one. Bits 15:12 hold the operation code and bits 11:0 hold the address X. Code 1 loads M[X] into AC. Code 2 writes AC to M[X].
- R3: Code 3 adds M[X] to AC and code 4 subtracts M[X] from AC. Both use 16-bit two's complement that wraps (0 - 1 gives 0xFFFF).
- R4: The indirect codes read the pointer P = M[X] bits 11:0 first. Code D loads M[P] into AC. Code E writes AC to M[P]. Code B adds M[P] to AC.
- R5: Code 8 tests AC by bits 11:10. With 00 it skips when AC is negative, with 01 when AC is zero, and with 10 when AC is positive. A skip adds one more to PC. The value 11 never skips.
- R6: Code 0 writes the return address (the address after the call) into M[X] and continues at X+1. Code C continues at the address held in M[X] bits 11:0.
- R7: Code 9 continues at X. Code A sets AC to zero.
- R8: The input register loads `in_data` only on a cycle with `in_stb` high. Code 5 copies it, zero-extended, into AC. Code 6 puts AC bits 7:0 into the output register.
- R9: Code 7 stops the core. `halted` goes high and stays high until reset, PC holds, and the core makes no further memory writes.
- R10: While the core is idle and `run` is low, the host port owns the memory. A write takes effect on the clock edge, and read data appears one cycle after the address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| run | input | 1 | High lets the core execute; low gives the memory to the host |
| in_data | input | 8 | Value offered to the input register |
| in_stb | input | 1 | Captures `in_data` into the input register |
| host_we | input | 1 | Host memory write enable (used when `run` is low) |
| host_addr | input | 12 | Host memory word address |
| host_wdata | input | 16 | Host memory write data |
| host_rdata | output | 16 | Memory read data, one cycle after the address |
| out_data | output | 8 | Output register contents |
| halted | output | 1 | High once a halt instruction has executed |

## Verification
The bench builds the core with its default sizes: 16-bit words, a 12-bit address field and 8-bit I/O registers. With these sizes, the test programs can sit anywhere in the 4K space, including a loop placed at 0x100 that sums five numbers through an indirect add. The sign bit sits at bit 15, so the skip tests can use negative, zero and positive accumulator values, and the wrap of 0 - 1 to 0xFFFF is visible. Because the accumulator is 16 bits and the output register is 8 bits, the bench can see that output keeps only the low byte and that input zero-extends.

// File: rtl/acc_pkg.sv
// Shared encodings for the accumulator core: operation codes, control
// states and ALU selects. Assumes a 4-bit operation field.
package acc_pkg;

    typedef enum logic [3:0] {
        OP_JNS    = 4'h0,
        OP_LOAD   = 4'h1,
        OP_STORE  = 4'h2,
        OP_ADD    = 4'h3,
        OP_SUBT   = 4'h4,
        OP_INPUT  = 4'h5,
        OP_OUTPUT = 4'h6,
        OP_HALT   = 4'h7,
        OP_SKIP   = 4'h8,
        OP_JUMP   = 4'h9,
        OP_CLEAR  = 4'hA,
        OP_ADDI   = 4'hB,
        OP_JUMPI  = 4'hC,
        OP_LOADI  = 4'hD,
        OP_STOREI = 4'hE,
        OP_NOP    = 4'hF
    } opcode_e;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_FADDR,
        ST_FWAIT,
        ST_FLOAD,
        ST_DECODE,
        ST_RWAIT,
        ST_RDATA,
        ST_INDIR,
        ST_EXEC,
        ST_WRITE,
        ST_HALT
    } state_e;

    typedef enum logic [1:0] {
        ALU_PASS,
        ALU_ADD,
        ALU_SUB
    } alu_op_e;

endpackage

// File: rtl/acc_mem.sv
// Single-port synchronous word memory. Write on the edge when we is high;
// read data is registered, so it appears one cycle after the address.
// Contents are not reset; they are expected to be loaded before use.
module acc_mem #(
    parameter int DW = 16,
    parameter int AW = 12
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    // Write port and registered read port
    always_ff @(posedge clk) begin
        if (we) mem[addr] <= wdata;
        rdata <= mem[addr];
    end

endmodule

// File: rtl/acc_alu.sv
// Combinational accumulator ALU: pass, add or subtract the operand, plus
// sign tests on the accumulator for the conditional skip.
module acc_alu
    import acc_pkg::*;
#(
    parameter int DW = 16
) (
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    input  alu_op_e       op,
    output logic [DW-1:0] y,
    output logic          neg,
    output logic          zero,
    output logic          pos
);
    // Result select
    always_comb begin
        unique case (op)
            ALU_ADD: y = a + b;
            ALU_SUB: y = a - b;
            default: y = b;
        endcase
    end

    // Accumulator sign tests
    always_comb begin
        neg  = a[DW-1];
        zero = (a == '0);
        pos  = !a[DW-1] && (a != '0);
    end

endmodule

// File: rtl/acc_core.sv
// Multi-cycle accumulator processor. A control FSM moves every instruction
// through MAR and MBR; the memory read takes one wait state. Assumes DW
// equals the operation field plus AW, and that run only falls while the core
// is idle or halted (the host port takes the memory whenever run is low).
module acc_core
    import acc_pkg::*;
#(
    parameter int DW  = 16,
    parameter int AW  = 12,
    parameter int IOW = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           run,
    input  logic [IOW-1:0] in_data,
    input  logic           in_stb,
    input  logic           host_we,
    input  logic [AW-1:0]  host_addr,
    input  logic [DW-1:0]  host_wdata,
    output logic [DW-1:0]  host_rdata,
    output logic [IOW-1:0] out_data,
    output logic           halted
);
    localparam int OPW = DW - AW;
    localparam logic [AW-1:0] ONE_A = AW'(1);

    state_e        state;
    logic [DW-1:0] ac, mbr, ir;
    logic [AW-1:0] pc, mar;
    logic [IOW-1:0] inreg, outreg;
    logic          ind_done;

    opcode_e       op;
    logic [AW-1:0] x;
    logic [1:0]    cond;
    logic          core_we, is_ind, take_skip;
    logic          mem_we;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_wd, mem_rd;
    alu_op_e       alu_sel;
    logic [DW-1:0] alu_y;
    logic          ac_neg, ac_zero, ac_pos;

    // Instruction field split
    always_comb begin
        op   = opcode_e'(ir[DW-1 -: OPW]);
        x    = ir[AW-1:0];
        cond = ir[AW-1 -: 2];
    end

    // Control decodes shared by the FSM and the memory mux
    always_comb begin
        core_we = (state == ST_WRITE);
        is_ind  = (op == OP_LOADI) || (op == OP_ADDI) || (op == OP_STOREI);
        unique case (op)
            OP_ADD, OP_ADDI: alu_sel = ALU_ADD;
            OP_SUBT:         alu_sel = ALU_SUB;
            default:         alu_sel = ALU_PASS;
        endcase
        unique case (cond)
            2'b00:   take_skip = ac_neg;
            2'b01:   take_skip = ac_zero;
            2'b10:   take_skip = ac_pos;
            default: take_skip = 1'b0;
        endcase
    end

    // Memory ownership: core while running, host otherwise
    always_comb begin
        mem_we   = run ? core_we : host_we;
        mem_addr = run ? mar     : host_addr;
        mem_wd   = run ? mbr     : host_wdata;
    end

    acc_mem #(.DW(DW), .AW(AW)) u_mem (
        .clk   (clk),
        .we    (mem_we),
        .addr  (mem_addr),
        .wdata (mem_wd),
        .rdata (mem_rd)
    );

    acc_alu #(.DW(DW)) u_alu (
        .a    (ac),
        .b    (mbr),
        .op   (alu_sel),
        .y    (alu_y),
        .neg  (ac_neg),
        .zero (ac_zero),
        .pos  (ac_pos)
    );

    // Input register capture
    always_ff @(posedge clk) begin
        if (!rst_n)      inreg <= '0;
        else if (in_stb) inreg <= in_data;
    end

    // Control FSM and register transfers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            ac       <= '0;
            pc       <= '0;
            mar      <= '0;
            mbr      <= '0;
            ir       <= '0;
            outreg   <= '0;
            ind_done <= 1'b0;
        end else begin
            unique case (state)
                ST_IDLE:  if (run) state <= ST_FADDR;
                ST_FADDR: begin
                    mar   <= pc;
                    state <= ST_FWAIT;
                end
                ST_FWAIT: state <= ST_FLOAD;
                ST_FLOAD: begin
                    ir       <= mem_rd;
                    pc       <= pc + ONE_A;
                    ind_done <= 1'b0;
                    state    <= ST_DECODE;
                end
                ST_DECODE: begin
                    state <= ST_FADDR;
                    unique case (op)
                        OP_JNS: begin
                            mar   <= x;
                            mbr   <= {{(DW-AW){1'b0}}, pc};
                            state <= ST_WRITE;
                        end
                        OP_STORE: begin
                            mar   <= x;
                            mbr   <= ac;
                            state <= ST_WRITE;
                        end
                        OP_LOAD, OP_ADD, OP_SUBT, OP_ADDI,
                        OP_JUMPI, OP_LOADI, OP_STOREI: begin
                            mar   <= x;
                            state <= ST_RWAIT;
                        end
                        OP_INPUT:  ac <= {{(DW-IOW){1'b0}}, inreg};
                        OP_OUTPUT: outreg <= ac[IOW-1:0];
                        OP_HALT:   state <= ST_HALT;
                        OP_SKIP:   if (take_skip) pc <= pc + ONE_A;
                        OP_JUMP:   pc <= x;
                        OP_CLEAR:  ac <= '0;
                        default:   ;
                    endcase
                end
                ST_RWAIT: state <= ST_RDATA;
                ST_RDATA: begin
                    mbr   <= mem_rd;
                    state <= (is_ind && !ind_done) ? ST_INDIR : ST_EXEC;
                end
                ST_INDIR: begin
                    mar      <= mbr[AW-1:0];
                    ind_done <= 1'b1;
                    if (op == OP_STOREI) begin
                        mbr   <= ac;
                        state <= ST_WRITE;
                    end else begin
                        state <= ST_RWAIT;
                    end
                end
                ST_EXEC: begin
                    if (op == OP_JUMPI) pc <= mbr[AW-1:0];
                    else                ac <= alu_y;
                    state <= ST_FADDR;
                end
                ST_WRITE: begin
                    if (op == OP_JNS) pc <= x + ONE_A;
                    state <= ST_FADDR;
                end
                ST_HALT: state <= ST_HALT;
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign host_rdata = mem_rd;
    assign out_data   = outreg;
    assign halted     = (state == ST_HALT);

    // R9: once stopped, the core stays stopped until reset
    assert_halt_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> halted);

    // R9: PC holds while stopped
    assert_halt_pc_R9: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> $stable(pc));

    // R9: no memory writes from a stopped core
    assert_halt_nowr_R9: assert property (@(posedge clk) disable iff (!rst_n)
        halted |-> !core_we);

    // R2: the fetched word lands in IR and PC steps by one
    assert_fetch_ir_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_FLOAD) |=> (ir == $past(mem_rd)));
    assert_fetch_pc_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_FLOAD) |=> (pc == $past(pc) + ONE_A));

    // R5: condition code 11 never moves PC
    assert_skip_never_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DECODE && op == OP_SKIP && cond == 2'b11) |=> (pc == $past(pc)));

    // R10: an idle core with run low stays idle
    assert_idle_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && !run) |=> (state == ST_IDLE));

endmodule

// File: tb/sim_acc_core.sv
`timescale 1ns/1ps
// Directed bench for acc_core: each task loads a program, runs it to halt
// and checks memory and ports against hand-computed results.
module sim_acc_core;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        run = 1'b0;
    logic [7:0]  in_data = '0;
    logic        in_stb = 1'b0;
    logic        host_we = 1'b0;
    logic [11:0] host_addr = '0;
    logic [15:0] host_wdata = '0;
    logic [15:0] host_rdata;
    logic [7:0]  out_data;
    logic        halted;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    acc_core u0 (
        .clk(clk), .rst_n(rst_n), .run(run), .in_data(in_data), .in_stb(in_stb),
        .host_we(host_we), .host_addr(host_addr), .host_wdata(host_wdata),
        .host_rdata(host_rdata), .out_data(out_data), .halted(halted)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        run = 1'b0; rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic wr(input logic [11:0] a, input logic [15:0] d);
        @(negedge clk);
        host_addr = a; host_wdata = d; host_we = 1'b1;
        @(negedge clk);
        host_we = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [15:0] d);
        @(negedge clk);
        host_addr = a;
        @(negedge clk);
        d = host_rdata;
    endtask

    task automatic run_prog(input string req);
        int n = 0;
        @(negedge clk);
        run = 1'b1;
        while (!halted && n < 5000) begin
            @(negedge clk);
            n++;
        end
        run = 1'b0;
        chk(req, {15'd0, halted}, 16'd1);
    endtask

    // R1 reset state and R10 host round trip
    task automatic t_reset();
        logic [15:0] d;
        do_reset();
        chk("R1 halted", {15'd0, halted}, 16'd0);
        chk("R1 out_data", {8'd0, out_data}, 16'd0);
        wr(12'h7F0, 16'hBEEF);
        rd(12'h7F0, d);
        chk("R10 host readback", d, 16'hBEEF);
    endtask

    // R4 R3 R5 R2 R7 R9: five-number summing loop through AddI
    task automatic t_sum();
        logic [15:0] d;
        do_reset();
        wr(12'h000, 16'h9100);
        wr(12'h100, 16'h1111); wr(12'h101, 16'h2112); wr(12'h102, 16'h1113);
        wr(12'h103, 16'h4116); wr(12'h104, 16'h2115); wr(12'h105, 16'h1114);
        wr(12'h106, 16'hB112); wr(12'h107, 16'h2114); wr(12'h108, 16'h1112);
        wr(12'h109, 16'h3116); wr(12'h10A, 16'h2112); wr(12'h10B, 16'h1115);
        wr(12'h10C, 16'h4116); wr(12'h10D, 16'h2115); wr(12'h10E, 16'h8000);
        wr(12'h10F, 16'h9105); wr(12'h110, 16'h7000);
        wr(12'h111, 16'h0117); wr(12'h112, 16'h0000); wr(12'h113, 16'h0005);
        wr(12'h114, 16'h0000); wr(12'h115, 16'h0000); wr(12'h116, 16'h0001);
        wr(12'h117, 16'd10); wr(12'h118, 16'd15); wr(12'h119, 16'd2);
        wr(12'h11A, 16'd25); wr(12'h11B, 16'd30);
        run_prog("R9 sum halts");
        rd(12'h114, d); chk("R4 sum via AddI", d, 16'd82);
        rd(12'h115, d); chk("R3 counter wraps", d, 16'hFFFF);
        rd(12'h112, d); chk("R2 pointer advanced", d, 16'h011C);
        repeat (10) @(negedge clk);
        chk("R9 halted sticky", {15'd0, halted}, 16'd1);
        rd(12'h114, d); chk("R9 no write after halt", d, 16'd82);
    endtask

    // R6: call through JnS and return through JumpI
    task automatic t_call();
        logic [15:0] d;
        do_reset();
        wr(12'h000, 16'h1040); wr(12'h001, 16'h0020);
        wr(12'h002, 16'h2041); wr(12'h003, 16'h7000);
        wr(12'h020, 16'h0000); wr(12'h021, 16'h3042); wr(12'h022, 16'hC020);
        wr(12'h040, 16'h0005); wr(12'h041, 16'h0000); wr(12'h042, 16'h0003);
        run_prog("R6 call halts");
        rd(12'h020, d); chk("R6 return address stored", d, 16'h0002);
        rd(12'h041, d); chk("R6 body ran and returned", d, 16'h0008);
    endtask

    // R4 R8 R7: LoadI, StoreI, Output, Input, Clear
    task automatic t_io();
        logic [15:0] d;
        do_reset();
        @(negedge clk); in_data = 8'hA5; in_stb = 1'b1;
        @(negedge clk); in_stb = 1'b0; in_data = 8'h3C;
        wr(12'h000, 16'hD030); wr(12'h001, 16'hE032); wr(12'h002, 16'h6000);
        wr(12'h003, 16'h5000); wr(12'h004, 16'h2034); wr(12'h005, 16'hA000);
        wr(12'h006, 16'h2035); wr(12'h007, 16'h7000);
        wr(12'h030, 16'h0031); wr(12'h031, 16'h1234); wr(12'h032, 16'h0033);
        wr(12'h033, 16'h0000); wr(12'h034, 16'h0000); wr(12'h035, 16'hFFFF);
        run_prog("R8 io halts");
        chk("R8 output low byte", {8'd0, out_data}, 16'h0034);
        rd(12'h033, d); chk("R4 LoadI then StoreI", d, 16'h1234);
        rd(12'h034, d); chk("R8 input zero-extended, no strobe ignored", d, 16'h00A5);
        rd(12'h035, d); chk("R7 clear", d, 16'h0000);
    endtask

    // R5: all four condition codes
    task automatic t_skip();
        logic [15:0] d;
        do_reset();
        wr(12'h000, 16'h1050); wr(12'h001, 16'h8000); wr(12'h002, 16'h2060);
        wr(12'h003, 16'h8400); wr(12'h004, 16'h2061); wr(12'h005, 16'hA000);
        wr(12'h006, 16'h8400); wr(12'h007, 16'h2062); wr(12'h008, 16'h8800);
        wr(12'h009, 16'h2063); wr(12'h00A, 16'h1051); wr(12'h00B, 16'h8800);
        wr(12'h00C, 16'h2064); wr(12'h00D, 16'h8C00); wr(12'h00E, 16'h2065);
        wr(12'h00F, 16'h7000);
        wr(12'h050, 16'hFFFF); wr(12'h051, 16'h0001);
        for (int i = 0; i < 6; i++) wr(12'h060 + 12'(i), 16'h7777);
        run_prog("R5 skip halts");
        rd(12'h060, d); chk("R5 neg skips", d, 16'h7777);
        rd(12'h061, d); chk("R5 zero test on neg", d, 16'hFFFF);
        rd(12'h062, d); chk("R5 zero skips", d, 16'h7777);
        rd(12'h063, d); chk("R5 pos test on zero", d, 16'h0000);
        rd(12'h064, d); chk("R5 pos skips", d, 16'h7777);
        rd(12'h065, d); chk("R5 code 11 never skips", d, 16'h0001);
    endtask

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        t_reset();
        t_sum();
        t_call();
        t_io();
        t_skip();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule